// File: doc/BRIEF.md
# Converter Three-Wire Serial Readout Interface

This block is the device-side digital logic of a converter that is read by a host over a three-wire serial link. The host starts a conversion with a rising edge on a convert-start line while holding a select line high. The select line is the same pin the device uses for data input. An internal timer, counted in system clocks, stands in for the conversion. When the timer expires, the parallel result supplied on `result_i` is captured and the block goes back to the acquisition phase, which counts as powered down. Conversion runs to its end whatever the select line does in the meantime.

After the conversion, the host pulls select low. The output driver turns on at once and presents the most significant bit. Each falling edge of the serial clock then moves the next lower bit onto the output. The driver turns off on the sixteenth falling edge, or earlier if select goes back high. Several devices can share one data line this way.

All three control inputs are asynchronous. Each is brought through a two-flop synchronizer into the system clock domain, and edges are found on the synchronized copies. A flag reports when convert-start and select are both low, which the host must never allow.

Top module: `adc_serial_if`

## Requirements
- R1: After reset `sdo_oe_o`, `conv_o`, `cs_mode_o` and `err_o` are all 0.
- R2: A rising edge on `cnv_i` while `sel_i` is high has the following effects, seen on the third system clock edge after the synchronizer sees the input change. `cs_mode_o` goes to 1, `sdo_oe_o` is 0, and `conv_o` goes high for exactly `CONV_CYCLES` clocks.
- R3: Conversion runs to its end regardless of `sel_i`. A falling edge on `sel_i` during conversion does not enable the output.
- R4: When conversion ends, `conv_o` returns to 0. If `sel_i` is high at that point, `sdo_oe_o` stays 0, so no busy indication appears.
- R5: The first falling edge of `sel_i` after a conversion sets `sdo_oe_o` to 1 with `sdo_o` equal to `result_i[15]`, the value captured at the end of conversion. Only one readout is started per conversion.
- R6: Each later falling edge of `sclk_i` puts the next lower result bit on `sdo_o`, so the bits come out most significant first.
- R7: On the 16th falling edge of `sclk_i`, `sdo_oe_o` returns to 0.
- R8: A rising edge on `sel_i` during a readout sets `sdo_oe_o` to 0 at once.
- R9: `err_o` is 1 while the synchronized `cnv_i` and `sel_i` are both low, and 0 otherwise.
- R10: A rising edge on `cnv_i` while `sel_i` is low clears `cs_mode_o` and starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert-start line (asynchronous) |
| sel_i | input | 1 | Select line that shares the data-in pin (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| result_i | input | DATA_W | Conversion result, captured when conversion ends |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data driver (0 = high impedance) |
| cs_mode_o | output | 1 | Set when chip-select mode was selected |
| conv_o | output | 1 | High during conversion |
| err_o | output | 1 | Convert-start and select both low |

## Verification
Each fault in internal state shows up at the pins in its own way:
- A conversion counter off by one moves the falling edge of `conv_o` by a clock. This is caught on the exact cycle, three clocks after the start edge plus `CONV_CYCLES`.
- A shift register that is loaded or stepped wrongly gives a wrong bit on `sdo_o`. This is seen at the first serial-clock falling edge that reaches the bad bit. The sweep of walking-one and dense patterns puts every bit position at both values.
- A bit counter that is off by one, or a readout flag that does not clear, leaves the driver enabled for one edge too many or too few. It can also allow a second readout from a single conversion. Either fault is caught within a few clocks of the 16th edge, or of the next select falling edge.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int CTRL_W      = 3;  // {sclk, sel, cnv}
  localparam logic [CTRL_W-1:0] CTRL_RST = 3'b010;
endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_d_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [adc_sif_pkg::SYNC_STAGES:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= {(adc_sif_pkg::SYNC_STAGES+1){RST_VAL[g]}};
      else         pipe <= {pipe[adc_sif_pkg::SYNC_STAGES-1:0], d_i[g]};
    end
    assign q_o[g]   = pipe[adc_sif_pkg::SYNC_STAGES-1];
    assign q_d_o[g] = pipe[adc_sif_pkg::SYNC_STAGES];
  end
endmodule

// File: rtl/adc_sif_ctrl.sv
module adc_sif_ctrl #(
  parameter int CONV_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnv_s_i,
  input  logic sel_s_i,
  input  logic cnv_rise_i,
  output logic start_o,
  output logic done_o,
  output logic conv_o,
  output logic mode_o,
  output logic err_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             conv_q, mode_q, err_q;

  assign start_o = cnv_rise_i && !conv_q && sel_s_i;
  assign done_o  = conv_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      conv_q <= 1'b0;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= !cnv_s_i && !sel_s_i;
      if (conv_q) begin
        if (cnt_q == '0) conv_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end else if (cnv_rise_i) begin
        mode_q <= sel_s_i;
        if (sel_s_i) begin
          conv_q <= 1'b1;
          cnt_q  <= CNT_LAST;
        end
      end
    end
  end

  assign conv_o = conv_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;
endmodule

// File: rtl/adc_sif_shift.sv
module adc_sif_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              conv_i,
  input  logic              sel_fall_i,
  input  logic              sel_rise_i,
  input  logic              sclk_fall_i,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sreg_q;
  logic [BIT_W-1:0]  bcnt_q;
  logic              oe_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      bcnt_q  <= '0;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      sreg_q  <= data_i;
      valid_q <= 1'b1;
    end else if (sel_rise_i) begin
      oe_q <= 1'b0;
    end else if (oe_q && sclk_fall_i) begin
      if (bcnt_q == BIT_LAST) begin
        oe_q <= 1'b0;
      end else begin
        sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
        bcnt_q <= bcnt_q + 1'b1;
      end
    end else if (sel_fall_i && valid_q && !conv_i) begin
      // one readout per conversion
      oe_q    <= 1'b1;
      bcnt_q  <= '0;
      valid_q <= 1'b0;
    end
  end

  assign sdo_o = sreg_q[DATA_W-1];
  assign oe_o  = oe_q;
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sel_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              cs_mode_o,
  output logic              conv_o,
  output logic              err_o
);
  import adc_sif_pkg::*;

  logic [CTRL_W-1:0] ctl_s, ctl_d;
  logic cnv_s, sel_s, sclk_s, cnv_d, sel_d, sclk_d;
  logic cnv_rise, sel_rise, sel_fall, sclk_fall;
  logic start, done;

  adc_sif_sync #(.W(CTRL_W), .RST_VAL(CTRL_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sel_i, cnv_i}),
    .q_o   (ctl_s),
    .q_d_o (ctl_d)
  );

  assign {sclk_s, sel_s, cnv_s} = ctl_s;
  assign {sclk_d, sel_d, cnv_d} = ctl_d;
  assign cnv_rise  = cnv_s && !cnv_d;
  assign sel_rise  = sel_s && !sel_d;
  assign sel_fall  = !sel_s && sel_d;
  assign sclk_fall = !sclk_s && sclk_d;

  adc_sif_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnv_s_i   (cnv_s),
    .sel_s_i   (sel_s),
    .cnv_rise_i(cnv_rise),
    .start_o   (start),
    .done_o    (done),
    .conv_o    (conv_o),
    .mode_o    (cs_mode_o),
    .err_o     (err_o)
  );

  adc_sif_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .load_i     (done),
    .data_i     (result_i),
    .conv_i     (conv_o),
    .sel_fall_i (sel_fall),
    .sel_rise_i (sel_rise),
    .sclk_fall_i(sclk_fall),
    .sdo_o      (sdo_o),
    .oe_o       (sdo_oe_o)
  );
endmodule

// File: rtl/adc_serial_if_chk.sv
module adc_serial_if_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cnv_s_i,
  input logic sel_s_i,
  input logic sel_rise_i,
  input logic sclk_fall_i,
  input logic conv_i,
  input logic sdo_i,
  input logic oe_i,
  input logic err_i
);
  a_r3_no_drive_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> !conv_i);

  a_r2_start_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_i) |-> !oe_i);

  a_r2_conv_min_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_i) |=> conv_i);

  a_r8_sel_rise_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rise_i |=> !oe_i);

  a_r9_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnv_s_i && !sel_s_i) |=> err_i);

  a_r9_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_s_i || sel_s_i) |=> !err_i);

  a_r6_hold_between_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && !sclk_fall_i && !sel_rise_i) |=> $stable(sdo_i));
endmodule

bind adc_serial_if adc_serial_if_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnv_s_i    (cnv_s),
  .sel_s_i    (sel_s),
  .sel_rise_i (sel_rise),
  .sclk_fall_i(sclk_fall),
  .conv_i     (conv_o),
  .sdo_i      (sdo_o),
  .oe_i       (sdo_oe_o),
  .err_i      (err_o)
);

// File: tb/adc_serial_if_bench.sv
module adc_serial_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int CONV_CYCLES = 24;
  localparam int NPAT = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cnv_i = 1'b0, sel_i = 1'b1, sclk_i = 1'b0;
  logic [DATA_W-1:0] result_i = '0;
  logic sdo_o, sdo_oe_o, cs_mode_o, conv_o, err_o;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_if #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_adc_serial_if (
    .clk_i(clk), .rst_ni(rst_ni), .cnv_i(cnv_i), .sel_i(sel_i), .sclk_i(sclk_i),
    .result_i(result_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .cs_mode_o(cs_mode_o), .conv_o(conv_o), .err_o(err_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DATA_W-1:0] pattern(int k);
    if (k < DATA_W) return DATA_W'(1) << k;
    if (k == DATA_W) return '0;
    if (k == DATA_W + 1) return '1;
    return DATA_W'(k * 40503 + 12345);
  endfunction

  task automatic start_conv(logic [DATA_W-1:0] val);
    result_i = val;
    cnv_i = 1'b0;
    wait_cyc(4);
    cnv_i = 1'b1;
  endtask

  task automatic finish_conv();
    wait_cyc(CONV_CYCLES + 5);
    check("R4 conv_o low after conversion", 32'(conv_o), 0);
    check("R4 no drive at end of conversion", 32'(sdo_oe_o), 0);
  endtask

  task automatic sclk_pulse();
    sclk_i = 1'b1;
    wait_cyc(3);
    sclk_i = 1'b0;
    wait_cyc(4);
  endtask

  task automatic read_all(logic [DATA_W-1:0] val);
    sel_i = 1'b0;
    wait_cyc(4);
    check("R5 output enabled on select fall", 32'(sdo_oe_o), 1);
    check("R5 msb first", 32'(sdo_o), 32'(val[DATA_W-1]));
    for (int i = 1; i < DATA_W; i++) begin
      sclk_pulse();
      check("R6 next lower bit", 32'(sdo_o), 32'(val[DATA_W-1-i]));
      check("R6 still driving", 32'(sdo_oe_o), 1);
    end
    sclk_pulse();
    check("R7 high impedance after 16th fall", 32'(sdo_oe_o), 0);
    sel_i = 1'b1;
    wait_cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(4);
    // R1
    check("R1 oe reset", 32'(sdo_oe_o), 0);
    check("R1 conv reset", 32'(conv_o), 0);
    check("R1 mode reset", 32'(cs_mode_o), 0);
    check("R1 err reset", 32'(err_o), 0);

    // R2: exact conversion window
    result_i = 16'hA5C3;
    cnv_i = 1'b1;
    wait_cyc(2);
    check("R2 conv not yet", 32'(conv_o), 0);
    wait_cyc(1);
    check("R2 conv starts", 32'(conv_o), 1);
    check("R2 chip-select mode", 32'(cs_mode_o), 1);
    check("R2 output hiz", 32'(sdo_oe_o), 0);
    wait_cyc(CONV_CYCLES - 1);
    check("R2 conv last cycle", 32'(conv_o), 1);
    wait_cyc(1);
    check("R2 conv ended", 32'(conv_o), 0);
    check("R4 no busy drive", 32'(sdo_oe_o), 0);
    read_all(16'hA5C3);
    // R5: no second readout
    sel_i = 1'b0;
    wait_cyc(4);
    check("R5 single readout per conversion", 32'(sdo_oe_o), 0);
    sel_i = 1'b1;
    wait_cyc(4);

    // R3: select activity during conversion
    start_conv(16'h3C96);
    wait_cyc(6);
    sel_i = 1'b0;
    wait_cyc(4);
    check("R3 conversion continues", 32'(conv_o), 1);
    check("R3 select fall ignored in conversion", 32'(sdo_oe_o), 0);
    sel_i = 1'b1;
    finish_conv();
    read_all(16'h3C96);

    // R8: early select rise
    start_conv(16'hF0F0);
    finish_conv();
    sel_i = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < 5; i++) sclk_pulse();
    check("R8 bit before abort", 32'(sdo_o), 32'(1'b0));
    sel_i = 1'b1;
    wait_cyc(4);
    check("R8 hiz on select rise", 32'(sdo_oe_o), 0);

    // R9: both low
    cnv_i = 1'b0;
    wait_cyc(4);
    check("R9 no err with select high", 32'(err_o), 0);
    sel_i = 1'b0;
    wait_cyc(4);
    check("R9 err while both low", 32'(err_o), 1);
    // R10: convert edge with select low
    cnv_i = 1'b1;
    wait_cyc(4);
    check("R9 err clears", 32'(err_o), 0);
    check("R10 mode cleared", 32'(cs_mode_o), 0);
    check("R10 no conversion", 32'(conv_o), 0);
    sel_i = 1'b1;
    wait_cyc(4);

    // sweep
    for (int k = 0; k < NPAT; k++) begin
      start_conv(pattern(k));
      finish_conv();
      result_i = ~pattern(k);
      read_all(pattern(k));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule